// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block paces a raster display. From a set of software-written timing registers it produces horizontal sync, vertical sync and data-enable strobes, along with the column and row of the pixel currently inside the visible window. Every line is divided into four segments in the order sync, back porch, active, front porch. Every frame is divided into the same four segments, counted in lines. Each segment length is stored as its count minus one. A separate bit sets the active level of each strobe. A data-polarity bit is held and driven out for the downstream pixel path.

A command bit starts and stops scanning. While scanning is stopped the counters sit at zero and every strobe rests at its inactive level. When scanning starts, the first cycle is pixel 0 of the horizontal sync on line 0 of the vertical sync. An interrupt status bit is set each time scanning enters a vertical sync, which covers both the start of scanning and every frame wrap. Writing 1 to the status bit clears it. The interrupt output is the status bit gated by a mask bit.

All logic runs on the pixel clock, and the register port is synchronous to that clock. There is no streaming data interface, so every pin is plain control or status.

Top module: `raster_timing_gen`

## Requirements
- R1: Each line consists of horizontal sync, back porch, active and front porch, in that order. The segments last H_SYNC+1, H_BACK+1, H_ACT+1 and H_FRONT+1 pixel clocks, where the registers are at addresses 4, 5, 6 and 7.
- R2: Each frame consists of vertical sync, back porch, active and front porch lines, in that order. The segments last V_SYNC+1, V_BACK+1, V_ACT+1 and V_FRONT+1 lines, where the registers are at addresses 8, 9, 10 and 11. The vertical sync starts together with a horizontal sync.
- R3: Data enable is active only when both axes are in their active segments. In that case x_o counts 0..H_ACT along the line and y_o counts 0..V_ACT down the frame. Outside its own active segment, each coordinate reads 0.
- R4: The polarity register is at address 3. Bit 0 sets the hsync level, bit 1 the vsync level, bit 2 the data-enable level and bit 3 the data level. A set bit makes the signal active-high. data_pol_o follows bit 3.
- R5: Writing bit 0 = 1 to the command register (address 0) starts scanning. The first cycle after that write is the first pixel of horizontal sync on the first vertical-sync line. Writing bit 0 = 0 stops scanning.
- R6: While stopped, and after reset, x_o and y_o are 0 and hsync_o, vsync_o and de_o sit at their inactive levels. All registers reset to 0, which makes every strobe active-low.
- R7: Status bit 0 (address 2) is set in the first cycle of each vertical sync, including the one at start. Writing 1 to it clears it. If a clear coincides with a set, the set wins.
- R8: irq_o equals status bit 0 AND mask bit 0, where the mask is at address 1.
- R9: Every register reads back its stored value at its own address. Addresses 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register address |
| reg_wdata | input | CW (12) | Register write data |
| reg_rdata | output | CW (12) | Register read data, combinational from reg_addr |
| hsync_o | output | 1 | Horizontal sync, polarity per R4 |
| vsync_o | output | 1 | Vertical sync, polarity per R4 |
| de_o | output | 1 | Data enable, polarity per R4 |
| data_pol_o | output | 1 | Data polarity for the pixel path |
| x_o | output | CW (12) | Active column |
| y_o | output | CW (12) | Active row |
| irq_o | output | 1 | Vertical-sync interrupt |

## Verification
The assertions assume that the timing registers and the polarity register are rewritten only while scanning is stopped. A change in mid-frame would shorten a segment under a running counter, or flip the meaning of a strobe between two samples. The bench respects this: it programs geometry and polarity only after a stop command and before the next start. It exercises mid-frame stop and restart, minimum one-cycle segments, inverted and mixed polarities, and a status clear timed onto a frame wrap.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_t;

  localparam int unsigned SEGS      = 4;
  localparam int unsigned AXES      = 2;
  localparam int unsigned NTMG      = SEGS * AXES;
  localparam int unsigned ADDR_CMD  = 0;
  localparam int unsigned ADDR_MASK = 1;
  localparam int unsigned ADDR_STAT = 2;
  localparam int unsigned ADDR_POL  = 3;
  localparam int unsigned ADDR_TMG  = 4;
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     step,
  input  logic [SEGS-1:0][CW-1:0]  seg_len,
  output phase_t                   phase_o,
  output logic [CW-1:0]            cnt_o,
  output logic                     wrap_o
);
  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          last;
  logic [1:0]    nxt;

  // >= keeps the counter bounded if a length shrinks under it
  assign last = cnt_q >= seg_len[phase_q];
  assign nxt  = phase_q + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (step) begin
      if (last) begin
        cnt_q   <= '0;
        phase_q <= phase_t'(nxt);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign wrap_o  = run && step && (phase_q == PH_FRONT) && last;
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned CW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  input  logic                    frame_wrap,
  output logic [CW-1:0]           rdata,
  output logic                    run_o,
  output logic                    mask_o,
  output logic                    stat_o,
  output logic [3:0]              pol_o,
  output logic [NTMG-1:0][CW-1:0] tmg_o
);
  logic                    run_q, mask_q, stat_q;
  logic [3:0]              pol_q;
  logic [NTMG-1:0][CW-1:0] tmg_q;
  logic                    hit_cmd, hit_stat, start_evt, set_evt, clr_evt;

  assign hit_cmd   = we && (addr == AW'(ADDR_CMD));
  assign hit_stat  = we && (addr == AW'(ADDR_STAT));
  assign start_evt = hit_cmd && wdata[0] && !run_q;
  assign set_evt   = start_evt || frame_wrap;
  assign clr_evt   = hit_stat && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mask_q <= 1'b0;
      stat_q <= 1'b0;
      pol_q  <= '0;
    end else begin
      if (hit_cmd) run_q <= wdata[0];
      if (we && addr == AW'(ADDR_MASK)) mask_q <= wdata[0];
      if (we && addr == AW'(ADDR_POL)) pol_q <= wdata[3:0];
      stat_q <= (stat_q && !clr_evt) || set_evt;
    end
  end

  for (genvar g = 0; g < NTMG; g++) begin : g_tmg
    always_ff @(posedge clk) begin
      if (!rst_n) tmg_q[g] <= '0;
      else if (we && addr == AW'(ADDR_TMG + g)) tmg_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CMD))  rdata[0]   = run_q;
    if (addr == AW'(ADDR_MASK)) rdata[0]   = mask_q;
    if (addr == AW'(ADDR_STAT)) rdata[0]   = stat_q;
    if (addr == AW'(ADDR_POL))  rdata[3:0] = pol_q;
    for (int g = 0; g < NTMG; g++) begin
      if (addr == AW'(ADDR_TMG + g)) rdata = tmg_q[g];
    end
  end

  assign run_o  = run_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign pol_o  = pol_q;
  assign tmg_o  = tmg_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          data_pol_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          irq_o
);
  logic                    run_q, mask_q, stat_q;
  logic [3:0]              pol_q;
  logic [NTMG-1:0][CW-1:0] tmg_q;
  logic [AXES:0]           carry;
  phase_t                  ph  [AXES];
  logic [CW-1:0]           cnt [AXES];
  logic                    hs_on, vs_on, h_act, v_act;

  rtg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .frame_wrap (carry[AXES]),
    .rdata      (reg_rdata),
    .run_o      (run_q),
    .mask_o     (mask_q),
    .stat_o     (stat_q),
    .pol_o      (pol_q),
    .tmg_o      (tmg_q)
  );

  // axis 0 steps every pixel; each further axis steps on the wrap of the one below
  assign carry[0] = 1'b1;
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    rtg_axis #(.CW(CW)) u_axis (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .step    (carry[a]),
      .seg_len (tmg_q[a*SEGS +: SEGS]),
      .phase_o (ph[a]),
      .cnt_o   (cnt[a]),
      .wrap_o  (carry[a+1])
    );
  end

  assign hs_on = run_q && (ph[0] == PH_SYNC);
  assign vs_on = run_q && (ph[1] == PH_SYNC);
  assign h_act = run_q && (ph[0] == PH_ACT);
  assign v_act = run_q && (ph[1] == PH_ACT);

  assign hsync_o    = hs_on ? pol_q[0] : !pol_q[0];
  assign vsync_o    = vs_on ? pol_q[1] : !pol_q[1];
  assign de_o       = (h_act && v_act) ? pol_q[2] : !pol_q[2];
  assign data_pol_o = pol_q[3];
  assign x_o        = h_act ? cnt[0] : '0;
  assign y_o        = v_act ? cnt[1] : '0;
  assign irq_o      = stat_q && mask_q;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [3:0]    pol,
  input logic          stat,
  input logic [CW-1:0] h_act,
  input logic [CW-1:0] v_act,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic [CW-1:0] x_o,
  input logic [CW-1:0] y_o
);
  logic de_on, hs_on, vs_on;
  assign de_on = (de_o == pol[2]);
  assign hs_on = (hsync_o == pol[0]);
  assign vs_on = (vsync_o == pol[1]);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (x_o == '0 && y_o == '0 && !de_on && !hs_on && !vs_on)); // R6

  AST_X_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (de_on && $past(de_on)) |-> (x_o == $past(x_o) + CW'(1))); // R3

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (de_on && $past(de_on)) |-> $stable(y_o)); // R2

  AST_DE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    de_on |-> (x_o <= h_act && y_o <= v_act)); // R3

  AST_STAT_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> (hs_on && vs_on && run)); // R7
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_q),
  .pol     (pol_q),
  .stat    (stat_q),
  .h_act   (tmg_q[2]),
  .v_act   (tmg_q[6]),
  .hsync_o (hsync_o),
  .vsync_o (vsync_o),
  .de_o    (de_o),
  .x_o     (x_o),
  .y_o     (y_o)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  localparam int AW = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          hsync_o, vsync_o, de_o, data_pol_o, irq_o;
  logic [CW-1:0] x_o, y_o;

  always #10 clk = ~clk;

  raster_timing_gen #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .data_pol_o(data_pol_o),
    .x_o(x_o), .y_o(y_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_tmg [8];
  bit m_run, m_mask, m_stat;
  bit [3:0] m_pol;
  int hpos, vpos;

  function automatic int len(int i);
    return m_tmg[i] + 1;
  endfunction
  function automatic int htot();
    return len(0) + len(1) + len(2) + len(3);
  endfunction
  function automatic int vtot();
    return len(4) + len(5) + len(6) + len(7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_tmg[i]) m_tmg[i] = 0;
      m_run = 0; m_mask = 0; m_stat = 0; m_pol = 0; hpos = 0; vpos = 0;
    end else begin
      bit fs, clr;
      fs  = (reg_we && reg_addr == 0 && reg_wdata[0] && !m_run) ||
            (m_run && hpos == htot() - 1 && vpos == vtot() - 1);
      clr = reg_we && reg_addr == 2 && reg_wdata[0];
      if (m_run) begin
        hpos++;
        if (hpos >= htot()) begin
          hpos = 0;
          vpos++;
          if (vpos >= vtot()) vpos = 0;
        end
      end
      if (reg_we) begin
        case (int'(reg_addr))
          0: begin m_run = reg_wdata[0]; if (!reg_wdata[0]) begin hpos = 0; vpos = 0; end end
          1: m_mask = reg_wdata[0];
          3: m_pol = reg_wdata[3:0];
          4, 5, 6, 7, 8, 9, 10, 11: m_tmg[int'(reg_addr) - 4] = int'(reg_wdata);
          default: ;
        endcase
      end
      m_stat = (m_stat && !clr) || fs;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int hb, vb, ex;
      bit hs, vs, ha, va;
      hb = len(0) + len(1);
      vb = len(4) + len(5);
      hs = m_run && hpos < len(0);
      vs = m_run && vpos < len(4);
      ha = m_run && hpos >= hb && hpos < hb + len(2);
      va = m_run && vpos >= vb && vpos < vb + len(6);
      chk("R1 hsync", int'(hsync_o), int'(hs ? m_pol[0] : !m_pol[0]));
      chk("R2 vsync", int'(vsync_o), int'(vs ? m_pol[1] : !m_pol[1]));
      chk("R3 de", int'(de_o), int'((ha && va) ? m_pol[2] : !m_pol[2]));
      ex = ha ? hpos - hb : 0;
      chk("R3 x", int'(x_o), ex);
      ex = va ? vpos - vb : 0;
      chk("R3 y", int'(y_o), ex);
      chk("R4 data_pol", int'(data_pol_o), int'(m_pol[3]));
      chk("R8 irq", int'(irq_o), int'(m_stat && m_mask));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = CW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic geom(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf);
    wr(4, hs - 1); wr(5, hb - 1); wr(6, ha - 1); wr(7, hf - 1);
    wr(8, vs - 1); wr(9, vb - 1); wr(10, va - 1); wr(11, vf - 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c_hs, c_vs, c_de, mx, my;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // reset state: all polarities 0 -> strobes idle high
    chk("R6 reset hsync", int'(hsync_o), 1);
    chk("R6 reset vsync", int'(vsync_o), 1);
    chk("R6 reset de", int'(de_o), 1);
    chk("R6 reset x", int'(x_o), 0);
    rd(2, 0, "R9 reset status");
    rd(6, 0, "R9 reset h active");

    // configuration A: line 2+1+4+1 = 8, frame 1+1+3+1 = 6 lines
    geom(2, 1, 4, 1, 1, 1, 3, 1);
    wr(3, 7);
    wr(1, 1);
    rd(6, 3, "R9 h active holds count minus one");
    rd(10, 2, "R9 v active holds count minus one");
    rd(3, 7, "R9 polarity readback");
    rd(13, 0, "R9 unused address");

    wr(0, 1);
    chk("R5 first cycle in hsync", int'(hsync_o), 1);
    chk("R5 first cycle in vsync", int'(vsync_o), 1);
    c_hs = 0; c_vs = 0; c_de = 0; mx = 0; my = 0;
    for (int i = 0; i < 48; i++) begin
      if (hsync_o) c_hs++;
      if (vsync_o) c_vs++;
      if (de_o) begin
        c_de++;
        if (int'(x_o) > mx) mx = int'(x_o);
        if (int'(y_o) > my) my = int'(y_o);
      end
      @(negedge clk);
    end
    chk("R1 hsync cycles per frame", c_hs, 12);
    chk("R2 vsync cycles per frame", c_vs, 8);
    chk("R3 de cycles per frame", c_de, 12);
    chk("R3 max x", mx, 3);
    chk("R3 max y", my, 2);
    rd(2, 1, "R7 status set at start");
    chk("R8 irq with mask set", int'(irq_o), 1);
    wr(2, 1);
    rd(2, 0, "R7 write one clears");
    repeat (100) @(negedge clk);

    // clear timed onto the frame wrap edge: set must win
    wr(2, 1);
    while (!(hpos == htot() - 1 && vpos == vtot() - 1)) @(negedge clk);
    reg_we = 1'b1; reg_addr = 2; reg_wdata = 1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(2, 1, "R7 set wins over clear");

    // stop: everything idles at inactive level (pol 7 -> idle low)
    wr(0, 0);
    for (int i = 0; i < 10; i++) begin
      chk("R6 stopped hsync", int'(hsync_o), 0);
      chk("R6 stopped de", int'(de_o), 0);
      chk("R6 stopped x", int'(x_o), 0);
      @(negedge clk);
    end
    rd(0, 0, "R5 stop readback");

    // masking
    wr(2, 1);
    wr(1, 0);
    wr(0, 1);
    chk("R8 masked irq low", int'(irq_o), 0);
    rd(2, 1, "R7 status set while masked");
    wr(1, 1);
    chk("R8 unmasked irq high", int'(irq_o), 1);
    repeat (60) @(negedge clk);

    // configuration B: all one-cycle segments, all active-low
    wr(0, 0);
    geom(1, 1, 1, 1, 1, 1, 1, 1);
    wr(3, 0);
    wr(2, 1);
    wr(0, 1);
    c_hs = 0; c_de = 0;
    for (int i = 0; i < 16; i++) begin
      if (!hsync_o) c_hs++;
      if (!de_o) c_de++;
      @(negedge clk);
    end
    chk("R1 minimum segments hsync", c_hs, 4);
    chk("R3 minimum segments de", c_de, 1);
    repeat (40) @(negedge clk);

    // configuration C: mixed polarity, uneven lengths, mid-frame restart
    wr(0, 0);
    geom(3, 2, 9, 1, 2, 1, 4, 2);
    wr(3, 10);
    wr(0, 1);
    chk("R4 data polarity high", int'(data_pol_o), 1);
    chk("R4 hsync active low", int'(hsync_o), 0);
    chk("R4 vsync active high", int'(vsync_o), 1);
    repeat (300) @(negedge clk);
    repeat (20) @(negedge clk);
    wr(0, 0);
    wr(0, 1);
    chk("R5 restart in hsync", int'(hsync_o), 0);
    chk("R5 restart x zero", int'(x_o), 0);
    repeat (200) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule